// File: doc/BRIEF.md
# Clock and Reset Controller Register File

This block is the software-visible register file of a power, reset and clock controller. A host reaches it over a simple bus with separate read and write strobes, a byte address inside a 4 KiB window and a data word. It keeps the configuration of the reference oscillator, three PLLs (core, memory and network), the core clock selection, a per-device reset vector and a clock-mux status word.

The block presents an always-ready clock tree. The oscillator ready bit and each PLL's lock and internal-feedback bits are forced to one whenever software writes those registers, so polling loops in boot code finish at once. Accesses that hit no register return zero and raise a one-cycle error pulse together with the response.

Top module: `clkrst_csr`

## Requirements
- R1: After reset the oscillator word reads 0xC000_0000 (enable bit 30 and ready bit 31 set). Each PLL config-0 word reads 0x8201_87C1: divR=1 in [5:0], divF=31 in [14:6], divQ=3 in [17:15], feedback-select bit 25 and lock bit 31. The core clock select reads 0x0000_0001, where bit 0 set selects the high-frequency reference. Every other register reads zero, and rvalid, err and rdata are low.
- R2: A write to the oscillator word stores the written data with bit 31 (ready) forced to one; all other bits, enable included, take the written value.
- R3: A write to any PLL config-0 word (core, memory, network) stores the written data with bits 25 and 31 forced to one.
- R4: Writes to the memory and network PLL config-1 words, the core clock select, the device reset vector and the clock-mux status word store the data unmodified.
- R5: Only wdata[31:0] is stored; the upper half of the wider write bus is discarded.
- R6: rvalid is high in the cycle after rd_en and low otherwise. rdata carries the selected word in that cycle and is zero in every cycle without a response.
- R7: A read from an unmapped offset returns rdata zero with rvalid high, and err pulses high in the same cycle.
- R8: A write to an unmapped offset changes no register, and err pulses high for one cycle in the cycle after the write strobe.
- R9: Any access whose address bits [1:0] are not zero is unmapped.
- R10: Word offsets: 0x00 oscillator, 0x04 core PLL cfg0, 0x08 memory PLL cfg0, 0x0C memory PLL cfg1, 0x10 network PLL cfg0, 0x14 network PLL cfg1, 0x18 core clock select, 0x1C device reset, 0x20 clock-mux status; offsets 0x24 to 0xFFC are unmapped.
- R11: A read and a write to the same register in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (12) | Byte address inside the window |
| wdata | input | WDATA_W (64) | Write data; only bits [31:0] are used |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read response valid |
| err | output | 1 | Unmapped-access pulse |

## Verification
Every result of this block is due exactly one clock edge after its strobe: register contents, rdata, rvalid and err all change at the edge that samples the access. The bench drives each strobe at a falling edge, lets one rising edge pass, and samples the outputs at the next falling edge. A read issued right after a write therefore sees the new contents, and the sample after that is an idle cycle in which rvalid, err and rdata must be zero.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;

    localparam int REG_W = 32;
    localparam int NREG  = 9;
    localparam int IDX_W = $clog2(NREG);

    typedef enum logic [IDX_W-1:0] {
        RG_OSC     = 4'd0,
        RG_CPLL0   = 4'd1,
        RG_MPLL0   = 4'd2,
        RG_MPLL1   = 4'd3,
        RG_NPLL0   = 4'd4,
        RG_NPLL1   = 4'd5,
        RG_CLKSEL  = 4'd6,
        RG_DEVRST  = 4'd7,
        RG_MUXSTAT = 4'd8
    } reg_id_e;

    // Oscillator word fields
    localparam int OSC_EN_BIT  = 30;
    localparam int OSC_RDY_BIT = 31;

    // PLL config-0 fields
    localparam int PLL_R_LSB   = 0;
    localparam int PLL_F_LSB   = 6;
    localparam int PLL_Q_LSB   = 15;
    localparam int PLL_FSE_BIT = 25;
    localparam int PLL_LCK_BIT = 31;

    localparam logic [5:0] PLL_R_DEF = 6'd1;
    localparam logic [8:0] PLL_F_DEF = 9'd31;
    localparam logic [2:0] PLL_Q_DEF = 3'd3;

    localparam logic [REG_W-1:0] OSC_FORCE = REG_W'(1) << OSC_RDY_BIT;
    localparam logic [REG_W-1:0] PLL_FORCE = (REG_W'(1) << PLL_FSE_BIT)
                                           | (REG_W'(1) << PLL_LCK_BIT);

    localparam logic [REG_W-1:0] OSC_RESET = OSC_FORCE | (REG_W'(1) << OSC_EN_BIT);
    localparam logic [REG_W-1:0] PLL_RESET = PLL_FORCE
                                           | (REG_W'(PLL_R_DEF) << PLL_R_LSB)
                                           | (REG_W'(PLL_F_DEF) << PLL_F_LSB)
                                           | (REG_W'(PLL_Q_DEF) << PLL_Q_LSB);
    localparam logic [REG_W-1:0] CLKSEL_REF = REG_W'(1);

    function automatic logic is_pll_cfg0(int idx);
        return idx == int'(RG_CPLL0) || idx == int'(RG_MPLL0) || idx == int'(RG_NPLL0);
    endfunction

    function automatic logic [REG_W-1:0] force_mask(int idx);
        if (idx == int'(RG_OSC))  return OSC_FORCE;
        if (is_pll_cfg0(idx))     return PLL_FORCE;
        return '0;
    endfunction

    function automatic logic [REG_W-1:0] reset_value(int idx);
        if (idx == int'(RG_OSC))    return OSC_RESET;
        if (is_pll_cfg0(idx))       return PLL_RESET;
        if (idx == int'(RG_CLKSEL)) return CLKSEL_REF;
        return '0;
    endfunction

endpackage

// File: rtl/clkrst_addr_dec.sv
module clkrst_addr_dec
    import clkrst_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [NREG-1:0]   sel
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] word_idx;
    logic              aligned;

    assign word_idx = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);

    // One select line per register; misaligned addresses select nothing (R9)
    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign sel[i] = aligned && (word_idx == WIDX_W'(i));
    end

    assign hit = |sel;

    // R10: at most one register is ever selected
    p_sel_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
    // R9: a misaligned address never hits
    p_misaligned_miss_r9: assert property (@(posedge clk) disable iff (rst)
        (addr[1:0] != 2'b00) |-> !hit);

endmodule

// File: rtl/clkrst_reg_slot.sv
module clkrst_reg_slot
    import clkrst_pkg::*;
#(
    parameter logic [REG_W-1:0] RST_VAL    = '0,
    parameter logic [REG_W-1:0] FORCE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] d,
    output logic [REG_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (we)
            q <= d | FORCE_MASK;
    end

    // R2/R3: forced status bits can never be observed cleared
    p_force_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (q & FORCE_MASK) == FORCE_MASK);
    // R4: bits outside the force mask take the written data exactly
    p_store_data_r4: assert property (@(posedge clk) disable iff (rst)
        we |=> ((q & ~FORCE_MASK) == ($past(d) & ~FORCE_MASK)));

endmodule

// File: rtl/clkrst_csr.sv
module clkrst_csr
    import clkrst_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int WDATA_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WDATA_W-1:0] wdata,
    output logic [REG_W-1:0]   rdata,
    output logic               rvalid,
    output logic               err
);
    logic                       hit;
    logic [NREG-1:0]            sel;
    logic [NREG-1:0][REG_W-1:0] regs;
    logic [REG_W-1:0]           wword;
    logic [REG_W-1:0]           rd_mux;

    // R5: the upper part of the write bus is dropped here
    assign wword = wdata[REG_W-1:0];

    clkrst_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
        .clk  (clk),
        .rst  (rst),
        .addr (addr),
        .hit  (hit),
        .sel  (sel)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        clkrst_reg_slot #(
            .RST_VAL    (reset_value(i)),
            .FORCE_MASK (force_mask(i))
        ) slot_i (
            .clk (clk),
            .rst (rst),
            .we  (wr_en && sel[i]),
            .d   (wword),
            .q   (regs[i])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel[i]) rd_mux = regs[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            err    <= 1'b0;
        end else begin
            rvalid <= rd_en;
            rdata  <= rd_en ? rd_mux : '0;
            err    <= (rd_en || wr_en) && !hit;
        end
    end

    // R6: every read strobe is answered in the next cycle
    p_read_resp_r6: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid);
    // R6: no response means the data lines are quiet
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata == '0));
    // R7: an erroring read delivers zero
    p_miss_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !hit) |=> (rvalid && err && rdata == '0));
    // R8: an unmapped write leaves every register untouched
    p_miss_write_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit) |=> ($stable(regs) && err));
    // R8: the error indication lasts one cycle when the bus goes idle
    p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (err && !$past(rd_en) && !$past(wr_en)) |-> 1'b0);

endmodule

// File: tb/clkrst_csr_tb_top.sv
module clkrst_csr_tb_top;

    localparam int NR = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic        err;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [NR];

    always #10 clk = ~clk;   // 50 MHz

    clkrst_csr dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .err(err)
    );

    function automatic logic [31:0] forced(int i);
        if (i == 0) return 32'h8000_0000;
        if (i == 1 || i == 2 || i == 4) return (32'd1 << 25) | (32'd1 << 31);
        return 32'd0;
    endfunction

    function automatic string req_of(int i);
        if (i == 0) return "R2";
        if (i == 1 || i == 2 || i == 4) return "R3";
        return "R4";
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Strobe at a falling edge; outputs are due after the next rising edge
    task automatic do_read(logic [11:0] a, output logic [31:0] d,
                           output logic v, output logic e);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata; v = rvalid; e = err;
    endtask

    task automatic do_write(logic [11:0] a, logic [63:0] d, output logic e);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        e = err;
    endtask

    task automatic verify_all(string req);
        logic [31:0] d; logic v, e;
        for (int i = 0; i < NR; i++) begin
            do_read(12'(i * 4), d, v, e);
            chk(req, d, model[i]);
            chk({req, "/R6 rvalid"}, {31'd0, v}, 32'd1);
            chk({req, " no err"}, {31'd0, e}, 32'd0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] d; logic v, e;
        logic [31:0] pats [5];
        logic [31:0] pll_def;
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hA5A5_5A5A;
        pats[3] = 32'h5A5A_A5A5; pats[4] = 32'h1234_5678;
        pll_def = 32'd1 | (32'd31 << 6) | (32'd3 << 15) | (32'd1 << 25) | (32'd1 << 31);

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: outputs quiet after reset
        chk("R1 rvalid", {31'd0, rvalid}, 32'd0);
        chk("R1 err", {31'd0, err}, 32'd0);
        chk("R1 rdata", rdata, 32'd0);

        for (int i = 0; i < NR; i++) model[i] = 32'd0;
        model[0] = 32'hC000_0000;
        model[1] = pll_def; model[2] = pll_def; model[4] = pll_def;
        model[6] = 32'd1;
        verify_all("R1/R10 reset");

        // R2 R3 R4 R5: every pattern into every register, junk in upper half
        for (int p = 0; p < 5; p++) begin
            for (int i = 0; i < NR; i++) begin
                logic [31:0] val;
                val = pats[p] ^ 32'(i * 32'h0101_0101);
                do_write(12'(i * 4), {~val, val}, e);
                chk({req_of(i), " write err"}, {31'd0, e}, 32'd0);
                model[i] = val | forced(i);
                do_read(12'(i * 4), d, v, e);
                chk({req_of(i), "/R5 readback"}, d, model[i]);
            end
        end

        // R2: enable bit clears while ready stays
        do_write(12'h000, 64'hFFFF_FFFF_0000_0000, e);
        model[0] = 32'h8000_0000;
        do_read(12'h000, d, v, e);
        chk("R2 osc enable clear", d, 32'h8000_0000);

        // R6: idle cycle after a response
        @(negedge clk);
        chk("R6 idle rvalid", {31'd0, rvalid}, 32'd0);
        chk("R6 idle rdata", rdata, 32'd0);
        chk("R6 idle err", {31'd0, err}, 32'd0);

        // R11: read and write together return the old value
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 12'h01C; wdata = 64'h0000_0000_DEAD_BEEF;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        chk("R11 old value", rdata, model[7]);
        model[7] = 32'hDEAD_BEEF;
        do_read(12'h01C, d, v, e);
        chk("R11 new value", d, 32'hDEAD_BEEF);

        // R7 R8: unmapped aligned offsets, sweeping the tail of the window
        for (int a = 12'h024; a < 12'h080; a += 4) begin
            do_read(12'(a), d, v, e);
            chk("R7 unmapped rdata", d, 32'd0);
            chk("R7 unmapped err", {31'd0, e}, 32'd1);
            chk("R7 rvalid", {31'd0, v}, 32'd1);
            do_write(12'(a), 64'hFFFF_FFFF_FFFF_FFFF, e);
            chk("R8 unmapped write err", {31'd0, e}, 32'd1);
        end
        do_read(12'hFFC, d, v, e);
        chk("R7 top of window", {d[30:0], e}, 32'd1);

        // R9: misaligned addresses inside mapped words
        for (int a = 0; a < 12'h024; a++) begin
            if ((a % 4) != 0) begin
                do_write(12'(a), 64'h0, e);
                chk("R9 misaligned write err", {31'd0, e}, 32'd1);
                do_read(12'(a), d, v, e);
                chk("R9 misaligned read", {d[30:0], e}, 32'd1);
            end
        end
        // R8: err pulse ends
        @(negedge clk);
        chk("R8 err one cycle", {31'd0, err}, 32'd0);
        verify_all("R8/R9 unchanged");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule